// File: doc/BRIEF.md
# Serial Flash Whole-Array Erase Command Controller

This block is the device-side command logic of a serial flash that accepts a one-byte erase-everything instruction. It oversamples the serial clock, chip select and data-in pins with the system clock, shifts opcodes in, and decides at the chip-select release whether to commit the erase. An accepted erase starts a self-timed busy period, lasting a parameterised number of system clock cycles, toward a memory array model. The array model fills itself with ones when it sees the start strobe and is told the erase is over by the end strobe.

A write-enable instruction must first set the write-enable latch. The erase then commits only when the protect inputs are all zero and chip select rises right after the eighth opcode bit. While the erase runs, the status byte can still be read. It shows the busy flag and the latch, and the latch clears on its own partway through. Every other instruction is ignored while the erase runs.

The command state machine has six states. C_IDLE waits for chip select to fall, then moves to C_OPCODE, which collects eight bits. After the eighth bit it moves to one of four states. C_HOLD_WREN follows a write-enable opcode and C_HOLD_ERASE follows an erase opcode. C_READ_SR follows a status-read opcode. C_SKIP takes an unknown opcode, or any opcode except status-read while busy. A ninth rising clock edge in either hold state moves it to C_SKIP. A high chip select returns every state to C_IDLE. The busy timer has two states: B_READY moves to B_ERASING on the start strobe, and B_ERASING returns to B_READY after its last counted cycle.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, no erase strobe has been issued, `so` is 0 and the status byte reads 00h.
- R2: Opcode 06h sent with exactly 8 bits, followed by chip select rising, sets the write-enable latch (status bit 1).
- R3: Opcodes C7h and 60h each commit an erase, with one `erase_go` pulse, when the latch is set, protection is zero and the device is idle. No other opcode value produces `erase_go`.
- R4: An erase opcode sent while the latch is clear produces no `erase_go`, and the status stays 00h.
- R5: An erase opcode sent with any nonzero `blk_prot` produces no `erase_go` and leaves the latch set.
- R6: If chip select rises after any bit count other than 8 (1 to 7, or 9 and more), no erase is committed, no latch is set, and the latch and busy flag keep their values.
- R7: Exactly TCE_CYCLES clock edges pass from the `erase_go` pulse to the `erase_end` pulse. The busy flag (status bit 0) reads 1 in between and 0 after `erase_end`.
- R8: The latch clears WEL_CLR_CYCLES cycles into the erase, while the busy flag still reads 1. It is 0 when `erase_end` is high.
- R9: Opcode 05h followed by further clock pulses returns the status byte, MSB first, with a new bit after each falling SCLK. The byte is {2'b00, blk_prot[3:0], latch, busy}. It can be read during an erase. `so` is 0 outside a status read.
- R10: While busy, the write-enable and erase opcodes have no effect: the latch is unchanged and no further `erase_go` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data in on rising edges, status out on falling edges |
| si | input | 1 | Serial data in, MSB first |
| blk_prot | input | 4 | Block-protect bits; any nonzero value blocks the erase |
| so | output | 1 | Serial status data out |
| erase_go | output | 1 | One-cycle strobe that starts the array erase |
| erase_end | output | 1 | One-cycle strobe on the last busy cycle |

## Verification
A wrong latch or busy flag shows up at the next status read, about sixteen serial clock periods later. A wrong commit decision shows up as a missing or extra `erase_go` within three system cycles of chip select rising. A timer that is off by even one cycle shows up as a wrong spacing between `erase_go` and `erase_end`. A latch that is cleared at the wrong time shows up as a mismatch in the status reads taken before and after the clear point.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [2:0] {
        C_IDLE,
        C_OPCODE,
        C_HOLD_WREN,
        C_HOLD_ERASE,
        C_READ_SR,
        C_SKIP
    } cmd_state_t;

    typedef enum logic {
        B_READY,
        B_ERASING
    } busy_state_t;

    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_RDSR    = 8'h05;
    localparam logic [7:0] OP_ERASE_A = 8'hC7;
    localparam logic [7:0] OP_ERASE_B = 8'h60;

    function automatic logic [7:0] pack_status(logic [3:0] bp, logic wel, logic wip);
        return {2'b00, bp, wel, wip};
    endfunction

    function automatic logic is_erase_op(logic [7:0] op);
        return (op == OP_ERASE_A) || (op == OP_ERASE_B);
    endfunction

endpackage

// File: rtl/sfe_pin_sync.sv
module sfe_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_pin
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RESET_VAL[g]}};
                end else begin
                    chain <= {chain[STAGES-2:0], pin_i[g]};
                end
            end
            assign lvl_o[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sfe_shift_in.sv
module sfe_shift_in #(
    parameter int W = 8,
    localparam int CW = $clog2(W) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          sample_i,
    input  logic          bit_i,
    output logic [CW-1:0] cnt_o,
    output logic [W-1:0]  nxt_o
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [W-2:0]  sh;
    logic [CW-1:0] cnt;

    assign nxt_o = {sh, bit_i};
    assign cnt_o = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clear_i) begin
            sh  <= '0;
            cnt <= '0;
        end else if (sample_i) begin
            sh <= nxt_o[W-2:0];
            if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sfe_busy_timer.sv
module sfe_busy_timer
    import sfe_pkg::*;
#(
    parameter int TCE     = 400000,
    parameter int WEL_CLR = 200000,
    localparam int CW = $clog2(TCE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic wel_clr_o,
    output logic done_o
);

    localparam logic [CW-1:0] LAST    = CW'(TCE - 1);
    localparam logic [CW-1:0] CLR_AT  = CW'(WEL_CLR - 1);

    busy_state_t   st, st_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= B_READY;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            B_READY:   if (start_i) st_nx = B_ERASING;
            B_ERASING: if (cnt == LAST) st_nx = B_READY;
            default:   st_nx = B_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (st == B_READY) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        busy_o    = (st == B_ERASING);
        done_o    = busy_o && (cnt == LAST);
        wel_clr_o = busy_o && (cnt == CLR_AT);
    end

endmodule

// File: rtl/sfe_status_tx.sv
module sfe_status_tx #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         fall_i,
    input  logic [W-1:0] status_i,
    output logic         so_o
);

    logic [W-2:0]  sh;
    logic [CW-1:0] cnt;
    logic          so_q;

    assign so_o = so_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            cnt  <= '0;
            so_q <= 1'b0;
        end else if (!active_i) begin
            sh   <= '0;
            cnt  <= '0;
            so_q <= 1'b0;
        end else if (fall_i) begin
            if (cnt == '0) begin
                so_q <= status_i[W-1];
                sh   <= status_i[W-2:0];
            end else begin
                so_q <= sh[W-2];
                sh   <= {sh[W-3:0], 1'b0};
            end
            cnt <= (cnt == CW'(W - 1)) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import sfe_pkg::*;
#(
    parameter int TCE_CYCLES     = 400000,
    parameter int WEL_CLR_CYCLES = TCE_CYCLES / 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       si,
    input  logic [3:0] blk_prot,
    output logic       so,
    output logic       erase_go,
    output logic       erase_end
);

    localparam int OPW = 8;
    localparam int BCW = $clog2(OPW) + 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(OPW - 1);

    logic [2:0]     pin_lvl;
    logic           cs_lvl, sck_lvl, si_lvl;
    logic           cs_prev, sck_prev;
    logic           cs_rise, cs_fall, sck_rise, sck_fall;
    logic [BCW-1:0] bit_cnt;
    logic [OPW-1:0] nxt_byte;
    cmd_state_t     st, st_nx;
    logic           wel;
    logic           go_q;
    logic           busy, wel_clr, done;
    logic [7:0]     status;

    sfe_pin_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b001)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i({si, sclk, cs_n}),
        .lvl_o(pin_lvl)
    );

    assign cs_lvl  = pin_lvl[0];
    assign sck_lvl = pin_lvl[1];
    assign si_lvl  = pin_lvl[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end

    assign cs_rise  =  cs_lvl  & ~cs_prev;
    assign cs_fall  = ~cs_lvl  &  cs_prev;
    assign sck_rise =  sck_lvl & ~sck_prev & ~cs_lvl;
    assign sck_fall = ~sck_lvl &  sck_prev & ~cs_lvl;

    sfe_shift_in #(.W(OPW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cs_lvl),
        .sample_i(sck_rise),
        .bit_i   (si_lvl),
        .cnt_o   (bit_cnt),
        .nxt_o   (nxt_byte)
    );

    sfe_busy_timer #(
        .TCE    (TCE_CYCLES),
        .WEL_CLR(WEL_CLR_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (go_q),
        .busy_o   (busy),
        .wel_clr_o(wel_clr),
        .done_o   (done)
    );

    assign status = pack_status(blk_prot, wel, busy);

    sfe_status_tx #(.W(8)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(st == C_READ_SR),
        .fall_i  (sck_fall),
        .status_i(status),
        .so_o    (so)
    );

    function automatic cmd_state_t decode_op(logic [7:0] op, logic is_busy);
        cmd_state_t r;
        if (op == OP_RDSR) begin
            r = C_READ_SR;
        end else if (is_busy) begin
            r = C_SKIP;
        end else if (op == OP_WREN) begin
            r = C_HOLD_WREN;
        end else if (is_erase_op(op)) begin
            r = C_HOLD_ERASE;
        end else begin
            r = C_SKIP;
        end
        return r;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= C_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            C_IDLE: begin
                if (cs_fall) st_nx = C_OPCODE;
            end
            C_OPCODE: begin
                if (sck_rise && bit_cnt == LAST_BIT) begin
                    st_nx = decode_op(nxt_byte, busy);
                end
            end
            C_HOLD_WREN, C_HOLD_ERASE: begin
                if (sck_rise) st_nx = C_SKIP;
            end
            C_READ_SR, C_SKIP: begin
                st_nx = st;
            end
            default: st_nx = C_IDLE;
        endcase
        if (cs_lvl) st_nx = C_IDLE;
    end

    // outputs and latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            go_q <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (cs_rise && st == C_HOLD_WREN && !busy) begin
                wel <= 1'b1;
            end
            if (cs_rise && st == C_HOLD_ERASE && wel && blk_prot == 4'd0 && !busy) begin
                go_q <= 1'b1;
            end
            if (wel_clr) begin
                wel <= 1'b0;
            end
        end
    end

    assign erase_go  = go_q;
    assign erase_end = done;

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_lvl,
    input logic       cs_rise,
    input logic       so,
    input logic       erase_go,
    input logic       erase_end,
    input logic       busy,
    input logic       wel,
    input logic [3:0] blk_prot
);

    // R3: a commit needs the latch
    a_r3_go_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> wel);

    // R5: a commit needs zero protection
    a_r5_go_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> ($past(blk_prot) == 4'd0));

    // R10: no commit while busy
    a_r10_no_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> !busy);

    // R7: busy follows the strobe
    a_r7_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> busy);

    // R7: idle after end strobe
    a_r7_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        erase_end |=> !busy);

    // R8: latch gone by the end
    a_r8_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        erase_end |-> !wel);

    // R2: the latch only rises after a chip-select release
    a_r2_wel_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise));

    // R9: output quiet when deselected
    a_r9_so_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |=> !so);

endmodule

bind flash_erase_ctrl flash_erase_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (cs_lvl),
    .cs_rise  (cs_rise),
    .so       (so),
    .erase_go (erase_go),
    .erase_end(erase_end),
    .busy     (busy),
    .wel      (wel),
    .blk_prot (blk_prot)
);

// File: tb/tb_flash_erase_ctrl.sv
`timescale 1ns/1ps
module tb_flash_erase_ctrl;

    localparam int TCE = 1600;
    localparam int WC  = 700;
    localparam int HP  = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, sclk, si;
    logic [3:0] blk_prot;
    logic       so, erase_go, erase_end;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int go_cnt = 0, end_cnt = 0, go_t = 0, dur = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_erase_ctrl #(
        .TCE_CYCLES    (TCE),
        .WEL_CLR_CYCLES(WC)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .si       (si),
        .blk_prot (blk_prot),
        .so       (so),
        .erase_go (erase_go),
        .erase_end(erase_end)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (erase_go) begin
            go_cnt <= go_cnt + 1;
            go_t   <= cyc;
        end
        if (erase_end) begin
            end_cnt <= end_cnt + 1;
            dur     <= cyc - go_t;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] op, input int nbits, input bit rd_en,
                        output logic [7:0] rd);
        rd = 8'h00;
        @(negedge clk);
        cs_n = 1'b0;
        tick(HP);
        for (int i = 0; i < nbits; i++) begin
            si = (i < 8) ? op[7-i] : 1'b0;
            tick(HP);
            sclk = 1'b1;
            tick(HP);
            sclk = 1'b0;
        end
        if (rd_en) begin
            for (int j = 0; j < 8; j++) begin
                tick(HP);
                rd[7-j] = so;
                sclk = 1'b1;
                tick(HP);
                sclk = 1'b0;
            end
        end
        tick(HP);
        cs_n = 1'b1;
        tick(2 * HP);
    endtask

    task automatic send(input logic [7:0] op, input int nbits);
        logic [7:0] d;
        xfer(op, nbits, 1'b0, d);
    endtask

    task automatic read_sr(output logic [7:0] v);
        xfer(8'h05, 8, 1'b1, v);
    endtask

    task automatic wait_end(input int target);
        while (end_cnt < target) tick(1);
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] sr;
        int g0;
        int exp_go;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; si = 1'b0; blk_prot = 4'd0;
        tick(10);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        check(so, 0, "R1 so after reset");
        check(go_cnt, 0, "R1 no strobe after reset");
        read_sr(sr);
        check(sr, 8'h00, "R1 status after reset");

        // R4 erase without latch
        send(8'hC7, 8);
        tick(3);
        check(go_cnt, 0, "R4 erase with latch clear");
        read_sr(sr);
        check(sr, 8'h00, "R4 status unchanged");

        // R6 write-enable with wrong bit counts
        send(8'h06, 7);
        read_sr(sr);
        check(sr, 8'h00, "R6 wren 7 bits");
        send(8'h06, 9);
        read_sr(sr);
        check(sr, 8'h00, "R6 wren 9 bits");

        // R2 write-enable
        send(8'h06, 8);
        read_sr(sr);
        check(sr, 8'h02, "R2 wren sets latch");

        // R6 erase with wrong bit counts
        for (int n = 1; n <= 12; n++) begin
            if (n != 8) begin
                send((n % 2) ? 8'hC7 : 8'h60, n);
                tick(3);
                check(go_cnt, 0, $sformatf("R6 erase with %0d bits", n));
            end
        end
        read_sr(sr);
        check(sr, 8'h02, "R6 latch kept after bad counts");

        // R5 protection sweep
        for (int v = 1; v < 16; v++) begin
            blk_prot = v[3:0];
            send((v % 2) ? 8'hC7 : 8'h60, 8);
            tick(3);
            check(go_cnt, 0, $sformatf("R5 erase blocked bp=%0d", v));
            read_sr(sr);
            check(sr, (v << 2) | 2, $sformatf("R5 status bp=%0d", v));
        end
        blk_prot = 4'd0;

        // R3 R9 R8 R10 R7 accepted erase
        send(8'hC7, 8);
        tick(3);
        check(go_cnt, 1, "R3 C7 commits");
        read_sr(sr);
        check(sr, 8'h03, "R9 status during erase, latch and busy set");
        while (cyc < go_t + WC + 100) tick(1);
        read_sr(sr);
        check(sr, 8'h01, "R8 latch cleared while busy");
        send(8'h06, 8);
        send(8'h60, 8);
        tick(3);
        check(go_cnt, 1, "R10 erase ignored while busy");
        read_sr(sr);
        check(sr, 8'h01, "R10 wren ignored while busy");
        wait_end(1);
        check(dur, TCE, "R7 erase duration");
        read_sr(sr);
        check(sr, 8'h00, "R7 busy cleared after end");

        // R3 second opcode
        send(8'h06, 8);
        send(8'h60, 8);
        tick(3);
        check(go_cnt, 2, "R3 60 commits");
        wait_end(2);
        check(dur, TCE, "R7 duration second erase");
        read_sr(sr);
        check(sr, 8'h00, "R8 latch clear after 60 erase");

        // R3 opcode sweep
        send(8'h06, 8);
        for (int op = 0; op < 256; op++) begin
            g0 = go_cnt;
            send(op[7:0], 8);
            tick(3);
            exp_go = (op == 8'hC7 || op == 8'h60) ? 1 : 0;
            check(go_cnt - g0, exp_go, $sformatf("R3 sweep opcode %02h", op));
            if (exp_go == 1) begin
                wait_end(end_cnt + 1);
                send(8'h06, 8);
            end
        end
        read_sr(sr);
        check(sr, 8'h02, "R2 latch held after sweep");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule